// File: doc/BRIEF.md
# Tile-Chain Query Match String

This block is one string of `N` tiles with its answer fixed at construction. Each tile owns one bit position and holds three constant bits: an operand-A bit, an operand-B bit and a sum bit. Across the string these constants form one correct ripple-carry addition. The carry into tile 0 is zero, and the carry out of the last tile is dropped. The string acts as a one-entry content-addressable memory. When it is asked "what is A + B?", it answers only if the query equals its built-in operands, and otherwise it stays silent.

A query is shifted in serially with the operand bits side by side. The same stream can feed many strings in parallel. When loading stops, an enable token starts at tile 0 and moves down one tile per clock. A tile passes the token on only if its latched query bits equal its constants. At the last tile the token is reflected and climbs back one tile per clock. When the token returns to tile 0, every tile latches its sum constant. The latched bits are then shifted down the string to the responder at the bottom, which emits them one per clock.

Top module: `tile_query_string`

## Requirements
- R1: While `rst_ni` is low, `match_o`, `resp_valid_o` and `resp_bit_o` are 0.
- R2: Each clock edge with `load_i` high shifts the bit pair (`qa_i`, `qb_i`) in at tile 0 and moves every held pair one tile down. The query is sent MSB first. After a load of N or more bits, only the last N pairs count, and the final pair lands in tile 0 (bit 0).
- R3: Suppose `load_i` is high at edge t and low at edge t+1. If the query equals the built-in operands, `match_o` is 1 from edge t+2N onward.
- R4: If any tile's A bit or B bit differs from its constant, `match_o` and `resp_valid_o` stay 0 until the next load. This holds for a mismatch at the first tile, the last tile, or an operand swap.
- R5: After a match as in R3, `resp_valid_o` is 1 at edges t+2N+2 through t+3N+1. On those edges `resp_bit_o` carries the built-in sum bits, MSB first. At every other edge both outputs are 0.
- R6: Once set, `match_o` stays 1 while `load_i` is low. The response is emitted only once per query.
- R7: An edge with `load_i` high clears `match_o`, `resp_valid_o` and `resp_bit_o` on that edge. This also aborts a response that is in progress.
- R8: The default constants encode 3 + 5 = 8 in 4 bits. Constants whose sum bits do not follow the carry chain stop elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| load_i | input | 1 | Query shift enable |
| qa_i | input | 1 | Serial operand A bit, MSB first |
| qb_i | input | 1 | Serial operand B bit, MSB first |
| match_o | output | 1 | Token has returned to tile 0 |
| resp_valid_o | output | 1 | Responder is emitting an answer bit |
| resp_bit_o | output | 1 | Answer bit, MSB first |

## Verification
The bench first sends the exact built-in query, which shows the token's round-trip timing and the order of the answer bits. It then sends queries that differ only in the A operand, only in the B operand, or with the operands swapped. These show that every tile checks both bits and that a block at either end of the string silences it. A load longer than N bits shows that only the last N pairs count. A reload during the response, and a second query sent back to back, show that stale answers are cleared and that the string can be re-armed.

// File: rtl/tqs_pkg.sv
package tqs_pkg;
  localparam int unsigned MAX_W = 64;

  // Sum constants must follow the ripple carry from a zero carry-in.
  function automatic bit chain_ok(input logic [MAX_W-1:0] a, input logic [MAX_W-1:0] b,
                                  input logic [MAX_W-1:0] s, input int unsigned n);
    logic c;
    bit   ok;
    c  = 1'b0;
    ok = 1'b1;
    for (int unsigned i = 0; i < MAX_W; i++) begin
      if (i < n) begin
        if (s[i] != (a[i] ^ b[i] ^ c)) ok = 1'b0;
        c = (a[i] & b[i]) | (c & (a[i] ^ b[i]));
      end
    end
    return ok;
  endfunction
endpackage

// File: rtl/tqs_tile.sv
module tqs_tile #(
  parameter logic A_BIT = 1'b0,
  parameter logic B_BIT = 1'b0,
  parameter logic S_BIT = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic qa_i,
  input  logic qb_i,
  output logic qa_o,
  output logic qb_o,
  input  logic dn_i,
  output logic dn_o,
  input  logic up_i,
  output logic up_o,
  input  logic latch_i,
  input  logic shift_i,
  input  logic s_i,
  output logic s_o
);
  logic qa_q, qb_q, dn_q, up_q, s_q;
  logic hit;

  assign hit = (qa_q == A_BIT) && (qb_q == B_BIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      qa_q <= 1'b0;
      qb_q <= 1'b0;
      dn_q <= 1'b0;
      up_q <= 1'b0;
      s_q  <= 1'b0;
    end else if (load_i) begin
      qa_q <= qa_i;
      qb_q <= qb_i;
      dn_q <= 1'b0;
      up_q <= 1'b0;
      s_q  <= 1'b0;
    end else begin
      if (dn_i && hit) dn_q <= 1'b1;
      if (up_i) up_q <= 1'b1;
      if (latch_i)      s_q <= S_BIT;
      else if (shift_i) s_q <= s_i;
    end
  end

  assign qa_o = qa_q;
  assign qb_o = qb_q;
  assign dn_o = dn_q;
  assign up_o = up_q;
  assign s_o  = s_q;
endmodule

// File: rtl/tqs_ctrl.sv
module tqs_ctrl #(
  parameter int unsigned N = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic head_up_i,
  input  logic tail_s_i,
  output logic launch_o,
  output logic latch_o,
  output logic shift_o,
  output logic resp_valid_o,
  output logic resp_bit_o
);
  localparam int unsigned CW = $clog2(N + 1);

  logic          load_q, done_q, rv_q, rb_q;
  logic [CW-1:0] cnt_q;

  assign launch_o = load_q && !load_i;
  assign latch_o  = head_up_i && !done_q && !load_i;
  assign shift_o  = (cnt_q != '0) && !load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      load_q <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      rv_q   <= 1'b0;
      rb_q   <= 1'b0;
    end else begin
      load_q <= load_i;
      if (load_i) begin
        done_q <= 1'b0;
        cnt_q  <= '0;
        rv_q   <= 1'b0;
        rb_q   <= 1'b0;
      end else if (latch_o) begin
        done_q <= 1'b1;
        cnt_q  <= CW'(N);
        rv_q   <= 1'b0;
        rb_q   <= 1'b0;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        rv_q  <= 1'b1;
        rb_q  <= tail_s_i;
      end else begin
        rv_q <= 1'b0;
        rb_q <= 1'b0;
      end
    end
  end

  assign resp_valid_o = rv_q;
  assign resp_bit_o   = rb_q;
endmodule

// File: rtl/tile_query_string.sv
module tile_query_string #(
  parameter int unsigned N = 4,
  parameter logic [N-1:0] TILE_A = N'(3),
  parameter logic [N-1:0] TILE_B = N'(5),
  parameter logic [N-1:0] TILE_S = N'(8)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic qa_i,
  input  logic qb_i,
  output logic match_o,
  output logic resp_valid_o,
  output logic resp_bit_o
);
  generate
    if (!tqs_pkg::chain_ok(64'(TILE_A), 64'(TILE_B), 64'(TILE_S), N)) begin : g_bad_chain
      $error("tile constants break the carry chain");
    end
  endgenerate

  logic [N:0]   qa_c, qb_c, dn_c, s_c;
  logic [N-1:0] up_in, up_out;
  logic         launch, latch, shift;

  assign qa_c[0] = qa_i;
  assign qb_c[0] = qb_i;
  assign dn_c[0] = launch;
  assign s_c[0]  = 1'b0;

  for (genvar k = 0; k < N; k++) begin : g_tile
    if (k == N - 1) begin : g_reflect
      assign up_in[k] = dn_c[k+1];
    end else begin : g_pass
      assign up_in[k] = up_out[k+1];
    end

    tqs_tile #(
      .A_BIT(TILE_A[k]),
      .B_BIT(TILE_B[k]),
      .S_BIT(TILE_S[k])
    ) u_tile (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (load_i),
      .qa_i   (qa_c[k]),
      .qb_i   (qb_c[k]),
      .qa_o   (qa_c[k+1]),
      .qb_o   (qb_c[k+1]),
      .dn_i   (dn_c[k]),
      .dn_o   (dn_c[k+1]),
      .up_i   (up_in[k]),
      .up_o   (up_out[k]),
      .latch_i(latch),
      .shift_i(shift),
      .s_i    (s_c[k]),
      .s_o    (s_c[k+1])
    );
  end

  tqs_ctrl #(.N(N)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (load_i),
    .head_up_i   (up_out[0]),
    .tail_s_i    (s_c[N]),
    .launch_o    (launch),
    .latch_o     (latch),
    .shift_o     (shift),
    .resp_valid_o(resp_valid_o),
    .resp_bit_o  (resp_bit_o)
  );

  assign match_o = up_out[0];
endmodule

// File: rtl/tqs_checker.sv
module tqs_checker #(
  parameter int unsigned N = 4
) (
  input logic clk_i,
  input logic rst_ni,
  input logic load_i,
  input logic match_o,
  input logic resp_valid_o,
  input logic resp_bit_o
);
  logic [31:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           run_q <= '0;
    else if (resp_valid_o) run_q <= run_q + 1;
    else                   run_q <= '0;
  end

  p_resp_needs_match_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |-> match_o);

  p_load_clears_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (!match_o && !resp_valid_o && !resp_bit_o));

  p_match_sticky_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !load_i) |=> match_o);

  p_match_after_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(match_o) |-> !$past(load_i));

  p_bit_quiet_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !resp_valid_o |-> !resp_bit_o);

  p_run_bounded_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_q <= N);
endmodule

bind tile_query_string tqs_checker #(.N(N)) u_tqs_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .load_i      (load_i),
  .match_o     (match_o),
  .resp_valid_o(resp_valid_o),
  .resp_bit_o  (resp_bit_o)
);

// File: tb/tile_query_string_bench.sv
`timescale 1ns/1ps
module tile_query_string_bench;
  localparam int N = 4;
  localparam logic [N-1:0] KA = 4'd3, KB = 4'd5, KS = 4'd8;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic load_i = 1'b0, qa_i = 1'b0, qb_i = 1'b0;
  logic match_o, resp_valid_o, resp_bit_o;

  int total = 0, bad = 0, wd = 0;
  string cur_req = "R1";

  // reference model state
  logic [N-1:0] m_qa = '0, m_qb = '0;
  bit  m_loadp = 0, m_ok = 0;
  int  m_cnt = -1;
  bit  e_match = 0, e_rv = 0, e_rb = 0;
  int  resp_seen = 0;

  always #2 clk = ~clk;

  tile_query_string #(.N(N), .TILE_A(KA), .TILE_B(KB), .TILE_S(KS)) u_tile_query_string (
    .clk_i(clk), .rst_ni(rst_ni), .load_i(load_i), .qa_i(qa_i), .qb_i(qb_i),
    .match_o(match_o), .resp_valid_o(resp_valid_o), .resp_bit_o(resp_bit_o));

  always @(posedge clk) begin
    if (!rst_ni) begin
      m_qa = '0; m_qb = '0; m_loadp = 0; m_ok = 0; m_cnt = -1;
    end else begin
      if (load_i) begin
        m_qa = {m_qa[N-2:0], qa_i};
        m_qb = {m_qb[N-2:0], qb_i};
        m_cnt = -1; m_ok = 0;
      end else if (m_loadp) begin
        m_cnt = 0;
        m_ok = (m_qa == KA) && (m_qb == KB);
      end else if (m_cnt >= 0 && m_cnt < 100000) begin
        m_cnt++;
      end
      m_loadp = load_i;
    end
    e_match = m_ok && (m_cnt >= 2*N - 1);
    e_rv = m_ok && (m_cnt >= 2*N + 1) && (m_cnt <= 3*N);
    e_rb = e_rv ? KS[N-1-(m_cnt-2*N-1)] : 1'b0;
  end

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni) begin
      chk(cur_req, "match_o", match_o, e_match);
      chk(cur_req, "resp_valid_o", resp_valid_o, e_rv);
      chk(cur_req, "resp_bit_o", resp_bit_o, e_rb);
      if (resp_valid_o) resp_seen++;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 100000) begin
      bad++; total++;
      $display("FAIL watchdog R1 actual=%0d expected<=100000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input logic l, input logic a, input logic b);
    @(negedge clk);
    load_i = l; qa_i = a; qb_i = b;
  endtask

  task automatic send(input logic [N-1:0] a, input logic [N-1:0] b);
    for (int i = N - 1; i >= 0; i--) step(1'b1, a[i], b[i]);
    step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0);
  endtask

  initial begin
    #1;
    cur_req = "R1";
    repeat (3) @(negedge clk);
    chk("R1", "match_o in reset", match_o, 1'b0);
    chk("R1", "resp_valid_o in reset", resp_valid_o, 1'b0);
    chk("R1", "resp_bit_o in reset", resp_bit_o, 1'b0);
    rst_ni = 1'b1;
    idle(2);

    cur_req = "R3";  // exact query, timing of the token round trip
    send(KA, KB);
    cur_req = "R5";
    resp_seen = 0;
    idle(4 * N);
    chk("R5", "answer bits emitted", resp_seen == N, 1'b1);
    cur_req = "R6";
    idle(3 * N);
    chk("R6", "match held, single answer", match_o && resp_seen == N, 1'b1);

    cur_req = "R4";  // A differs at the last tile
    resp_seen = 0;
    send(KA ^ 4'b1000, KB);
    idle(4 * N);
    send(KA, KB ^ 4'b0001);  // B differs at tile 0
    idle(4 * N);
    send(KB, KA);            // operands swapped
    idle(4 * N);
    chk("R4", "silent after mismatches", (resp_seen == 0) && !match_o, 1'b1);

    cur_req = "R2";  // longer load: garbage prefix is shifted out
    step(1'b1, 1'b1, 1'b0);
    step(1'b1, 1'b0, 1'b1);
    send(KA, KB);
    idle(4 * N);
    chk("R2", "match after long load", match_o, 1'b1);

    cur_req = "R7";  // reload aborts a response in progress
    send(KA, KB);
    idle(2 * N + 2);
    send(KA ^ 4'b0010, KB);
    chk("R7", "cleared by reload", match_o | resp_valid_o, 1'b0);
    idle(4 * N);

    cur_req = "R8";  // back-to-back queries against the default 3+5=8 string
    resp_seen = 0;
    send(KA, KB);
    send(KA, KB);
    idle(4 * N);
    chk("R8", "default string answers 8", resp_seen == N, 1'b1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule